// File: doc/BRIEF.md
# Serial DAC Code Loader with Range Detection

This block takes a three-wire serial write (a serial clock, a data line and a load strobe) from a host controller and keeps the code that a loop-current DAC is programmed with. Bits enter a shift register on rising serial-clock edges, most significant bit first. A rising edge on the load strobe moves the shift register into the code register. No separate mode bit is sent. The block counts the serial-clock edges seen since the previous load strobe, modulo 32, and that count selects the mode. A count from 0 to 16 selects normal range, which uses a 16-bit code spanning 4 mA to 20 mA. A count from 17 to 31 selects alarm range, which uses a 17-bit code spanning 0 mA to 32 mA. A longer write keeps only the bits that arrived last.

All four input pins are asynchronous to the system clock. Each pin passes through a two-flop synchroniser, and the clock and strobe pins then go through a rising-edge detector. A change on a pin therefore reaches the outputs three system-clock cycles later. For the downstream modulator, the block presents the code as a single 17-bit current word in units of 16 mA/65536 (about 244 nA). It also raises a flag when an alarm code lies outside the span the output stage can actually produce. An overload input clears the code and the frame state and removes the modulator enable for as long as it stays asserted.

The outputs are levels held in registers. A downstream modulator reads the current word continuously, so it cannot exert back-pressure and no valid/ready pair is needed. Every pin is a plain control or status signal.

Top module: `serial_dac_loader`

## Requirements
- R1: During and after reset, the outputs are code_o = 0, alarm_mode_o = 0, cur_word_o = 16384, range_err_o = 0 and mod_en_o = 1.
- R2: ser_data_i is shifted in on each rising edge of ser_clk_i, most significant bit first. code_o changes only on a rising edge of ser_latch_i. Any pin change reaches the outputs three clk cycles after it is sampled.
- R3: The count of ser_clk_i rising edges since the last ser_latch_i rising edge is kept modulo 32. A count of 0 to 16 selects normal mode (alarm_mode_o = 0). A count of 17 to 31 selects alarm mode (alarm_mode_o = 1). The count restarts at zero on every ser_latch_i rising edge.
- R4: In normal mode, code_o[15:0] takes the last 16 bits received and code_o[16] is 0.
- R5: In alarm mode, code_o[16:0] takes the last 17 bits received, and any earlier bits of a longer write are dropped.
- R6: cur_word_o equals code_o + 16384 in normal mode and equals code_o in alarm mode.
- R7: range_err_o is 1 exactly when alarm mode is selected and cur_word_o is below 14336 or above 98304. It is never 1 in normal mode.
- R8: While overload_i is high, mod_en_o = 0, code_o = 0 and alarm_mode_o = 0, and serial clocks and load strobes have no effect. After overload_i is released, mod_en_o returns to 1 and the code stays at 0 until the next load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ser_clk_i | input | 1 | Serial clock, asynchronous |
| ser_data_i | input | 1 | Serial data, asynchronous |
| ser_latch_i | input | 1 | Load strobe, asynchronous |
| overload_i | input | 1 | Overload condition, asynchronous level |
| code_o | output | 17 | Latched DAC code |
| alarm_mode_o | output | 1 | 1 when alarm range is selected |
| cur_word_o | output | 17 | Current word in 244 nA units |
| range_err_o | output | 1 | Alarm word outside the 3.5 mA to 24 mA span |
| mod_en_o | output | 1 | Modulator enable |

## Verification
The writes contain 16, 17, 24, 32 and 33 serial clocks. Together they separate the two range decisions, show the modulo-32 wrap (32 edges give normal mode, 33 edges give normal mode with one bit), and show that only the trailing bits of a long write are kept. A load strobe with no clocks after an alarm write shows that the edge count restarts and that stale shift bits are reused as a normal code. Alarm codes at 14335, 14336, 98304 and 98305 exercise both edges of the range flag. An overload pulse with a write and a strobe inside it shows that the clear has priority and that activity during the overload is ignored.

// File: rtl/sdl_pkg.sv
package sdl_pkg;
  typedef enum logic {
    MODE_NORMAL = 1'b0,
    MODE_ALARM  = 1'b1
  } mode_e;

  // index of each synchronised pin in the top-level pin vector
  localparam int PIN_SCLK = 0;
  localparam int PIN_SDAT = 1;
  localparam int PIN_LOAD = 2;
  localparam int PIN_OVL  = 3;
  localparam int PIN_N    = 4;
endpackage

// File: rtl/sdl_pin_sync.sv
module sdl_pin_sync #(
  parameter int STAGES      = 2,
  parameter bit DETECT_RISE = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic sig_o
);
  localparam int DEPTH = STAGES + (DETECT_RISE ? 1 : 0);

  logic [DEPTH-1:0] pipe_q;

  always_ff @(posedge clk) begin
    if (!rst_n) pipe_q <= '0;
    else        pipe_q <= {pipe_q[DEPTH-2:0], pin_i};
  end

  generate
    if (DETECT_RISE) begin : g_rise
      assign sig_o = pipe_q[STAGES-1] & ~pipe_q[STAGES];
    end else begin : g_level
      assign sig_o = pipe_q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/sdl_frame_shifter.sv
module sdl_frame_shifter #(
  parameter int SHIFT_W = 17,
  parameter int CNT_W   = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clear_i,
  input  logic               sclk_rise_i,
  input  logic               sdat_i,
  input  logic               load_rise_i,
  output logic [SHIFT_W-1:0] shift_o,
  output logic [CNT_W-1:0]   count_o
);
  logic [SHIFT_W-1:0] shift_q;
  logic [CNT_W-1:0]   count_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clear_i) begin
      shift_q <= '0;
      count_q <= '0;
    end else begin
      if (sclk_rise_i) shift_q <= {shift_q[SHIFT_W-2:0], sdat_i};
      // the counter wraps naturally at 2**CNT_W
      if (load_rise_i)      count_q <= sclk_rise_i ? CNT_W'(1) : '0;
      else if (sclk_rise_i) count_q <= count_q + CNT_W'(1);
    end
  end

  assign shift_o = shift_q;
  assign count_o = count_q;
endmodule

// File: rtl/sdl_code_latch.sv
module sdl_code_latch
  import sdl_pkg::*;
#(
  parameter int NORM_W  = 16,
  parameter int ALARM_W = 17,
  parameter int CNT_W   = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ovl_i,
  input  logic               load_rise_i,
  input  logic [ALARM_W-1:0] shift_i,
  input  logic [CNT_W-1:0]   count_i,
  output logic [ALARM_W-1:0] code_o,
  output mode_e              mode_o,
  output logic               mod_en_o
);
  localparam logic [CNT_W-1:0] NORM_LIMIT = CNT_W'(NORM_W);

  logic               pick_alarm;
  logic [ALARM_W-1:0] next_code;
  logic [ALARM_W-1:0] code_q;
  mode_e              mode_q;
  logic               en_q;

  assign pick_alarm = (count_i > NORM_LIMIT);
  assign next_code  = pick_alarm ? shift_i
                                 : {{(ALARM_W-NORM_W){1'b0}}, shift_i[NORM_W-1:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      code_q <= '0;
      mode_q <= MODE_NORMAL;
      en_q   <= 1'b1;
    end else if (ovl_i) begin
      code_q <= '0;
      mode_q <= MODE_NORMAL;
      en_q   <= 1'b0;
    end else begin
      en_q <= 1'b1;
      if (load_rise_i) begin
        code_q <= next_code;
        mode_q <= pick_alarm ? MODE_ALARM : MODE_NORMAL;
      end
    end
  end

  assign code_o   = code_q;
  assign mode_o   = mode_q;
  assign mod_en_o = en_q;
endmodule

// File: rtl/sdl_current_scale.sv
module sdl_current_scale
  import sdl_pkg::*;
#(
  parameter int ALARM_W = 17,
  parameter int OFFSET  = 16384,
  parameter int LO_LIM  = 14336,
  parameter int HI_LIM  = 98304
) (
  input  logic [ALARM_W-1:0] code_i,
  input  mode_e              mode_i,
  output logic [ALARM_W-1:0] word_o,
  output logic               range_err_o
);
  localparam logic [ALARM_W-1:0] OFS = ALARM_W'(OFFSET);
  localparam logic [ALARM_W-1:0] LO  = ALARM_W'(LO_LIM);
  localparam logic [ALARM_W-1:0] HI  = ALARM_W'(HI_LIM);

  always_comb begin
    word_o      = (mode_i == MODE_ALARM) ? code_i : code_i + OFS;
    range_err_o = (mode_i == MODE_ALARM) && ((word_o < LO) || (word_o > HI));
  end
endmodule

// File: rtl/serial_dac_loader.sv
module serial_dac_loader
  import sdl_pkg::*;
#(
  parameter int NORM_W      = 16,
  parameter int ALARM_W     = 17,
  parameter int CNT_W       = 5,
  parameter int SYNC_STAGES = 2,
  parameter int OFFSET      = 16384,
  parameter int LO_LIM      = 14336,
  parameter int HI_LIM      = 98304
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ser_clk_i,
  input  logic               ser_data_i,
  input  logic               ser_latch_i,
  input  logic               overload_i,
  output logic [ALARM_W-1:0] code_o,
  output logic               alarm_mode_o,
  output logic [ALARM_W-1:0] cur_word_o,
  output logic               range_err_o,
  output logic               mod_en_o
);
  logic [PIN_N-1:0] pin_raw;
  logic [PIN_N-1:0] pin_sync;
  logic [ALARM_W-1:0] shift_w;
  logic [CNT_W-1:0]   count_w;
  mode_e              mode_w;

  assign pin_raw[PIN_SCLK] = ser_clk_i;
  assign pin_raw[PIN_SDAT] = ser_data_i;
  assign pin_raw[PIN_LOAD] = ser_latch_i;
  assign pin_raw[PIN_OVL]  = overload_i;

  // clock and strobe pins become one-cycle rise pulses; data and overload stay levels
  generate
    for (genvar p = 0; p < PIN_N; p++) begin : g_sync
      sdl_pin_sync #(
        .STAGES     (SYNC_STAGES),
        .DETECT_RISE((p == PIN_SCLK) || (p == PIN_LOAD))
      ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .pin_i(pin_raw[p]),
        .sig_o(pin_sync[p])
      );
    end
  endgenerate

  sdl_frame_shifter #(
    .SHIFT_W(ALARM_W),
    .CNT_W  (CNT_W)
  ) u_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear_i    (pin_sync[PIN_OVL]),
    .sclk_rise_i(pin_sync[PIN_SCLK]),
    .sdat_i     (pin_sync[PIN_SDAT]),
    .load_rise_i(pin_sync[PIN_LOAD]),
    .shift_o    (shift_w),
    .count_o    (count_w)
  );

  sdl_code_latch #(
    .NORM_W (NORM_W),
    .ALARM_W(ALARM_W),
    .CNT_W  (CNT_W)
  ) u_latch (
    .clk        (clk),
    .rst_n      (rst_n),
    .ovl_i      (pin_sync[PIN_OVL]),
    .load_rise_i(pin_sync[PIN_LOAD]),
    .shift_i    (shift_w),
    .count_i    (count_w),
    .code_o     (code_o),
    .mode_o     (mode_w),
    .mod_en_o   (mod_en_o)
  );

  sdl_current_scale #(
    .ALARM_W(ALARM_W),
    .OFFSET (OFFSET),
    .LO_LIM (LO_LIM),
    .HI_LIM (HI_LIM)
  ) u_scale (
    .code_i     (code_o),
    .mode_i     (mode_w),
    .word_o     (cur_word_o),
    .range_err_o(range_err_o)
  );

  assign alarm_mode_o = (mode_w == MODE_ALARM);
endmodule

// File: rtl/sdl_checker.sv
module sdl_checker #(
  parameter int ALARM_W = 17
) (
  input logic               clk,
  input logic               rst_n,
  input logic               overload_i,
  input logic [ALARM_W-1:0] code_o,
  input logic               alarm_mode_o,
  input logic [ALARM_W-1:0] cur_word_o,
  input logic               range_err_o,
  input logic               mod_en_o
);
  AST_NORMAL_CODE_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
    !alarm_mode_o |-> (code_o[ALARM_W-1] == 1'b0)); // R4

  AST_NORMAL_WORD_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
    !alarm_mode_o |-> ((cur_word_o >= 17'd16384) && (cur_word_o <= 17'd81919))); // R6

  AST_ALARM_WORD_EQ: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_mode_o |-> (cur_word_o == code_o)); // R6

  AST_RANGE_ONLY_ALARM: assert property (@(posedge clk) disable iff (!rst_n)
    range_err_o |-> (alarm_mode_o && ((cur_word_o < 17'd14336) || (cur_word_o > 17'd98304)))); // R7

  AST_OVERLOAD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (overload_i && $past(overload_i) && $past(overload_i, 2))
      |=> (!mod_en_o && (code_o == '0) && !alarm_mode_o)); // R8
endmodule

bind serial_dac_loader sdl_checker #(.ALARM_W(ALARM_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .overload_i  (overload_i),
  .code_o      (code_o),
  .alarm_mode_o(alarm_mode_o),
  .cur_word_o  (cur_word_o),
  .range_err_o (range_err_o),
  .mod_en_o    (mod_en_o)
);

// File: tb/serial_dac_loader_tb.sv
`timescale 1ns/1ps
module serial_dac_loader_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, sdat = 1'b0, sload = 1'b0, ovl = 1'b0;
  logic [16:0] code_o, cur_word_o;
  logic alarm_mode_o, range_err_o, mod_en_o;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit finished = 1'b0;
  string cur_req = "R1";

  // behavioural model state
  int  m_sh = 0, m_cnt = 0, m_code = 0;
  bit  m_alarm = 0, m_en = 1, p_clk = 0, p_load = 0;
  int  q_code[$];
  bit  q_alarm[$];
  bit  q_en[$];

  always #2.5 clk = ~clk;

  serial_dac_loader u_dut (
    .clk(clk), .rst_n(rst_n),
    .ser_clk_i(sclk), .ser_data_i(sdat), .ser_latch_i(sload), .overload_i(ovl),
    .code_o(code_o), .alarm_mode_o(alarm_mode_o), .cur_word_o(cur_word_o),
    .range_err_o(range_err_o), .mod_en_o(mod_en_o)
  );

  function automatic int word_of(int c, bit a);
    return a ? c : c + 16384;
  endfunction

  function automatic bit err_of(int c, bit a);
    return a && ((c < 14336) || (c > 98304));
  endfunction

  task automatic cmp(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // apply current pins to the model, then compare one clock later
  task automatic step();
    bit rc, rl;
    int ec, w;
    bit ea, ee;
    rc = sclk & ~p_clk;
    rl = sload & ~p_load;
    p_clk = sclk;
    p_load = sload;
    if (ovl) begin
      m_sh = 0; m_cnt = 0; m_code = 0; m_alarm = 0; m_en = 0;
    end else begin
      m_en = 1;
      if (rl) begin
        if (m_cnt <= 16) begin m_code = m_sh & 32'hFFFF;  m_alarm = 0; end
        else             begin m_code = m_sh & 32'h1FFFF; m_alarm = 1; end
        m_cnt = 0;
      end
      if (rc) begin
        m_sh  = ((m_sh << 1) | int'(sdat)) & 32'h1FFFF;
        m_cnt = (m_cnt + 1) % 32;
      end
    end
    q_code.push_back(m_code);
    q_alarm.push_back(m_alarm);
    q_en.push_back(m_en);
    @(negedge clk);
    ec = q_code.pop_front();
    ea = q_alarm.pop_front();
    ee = q_en.pop_front();
    w  = word_of(ec, ea);
    cmp(cur_req, "model code", int'(code_o), ec);
    cmp(cur_req, "model mode", int'(alarm_mode_o), int'(ea));
    cmp(cur_req, "model word", int'(cur_word_o), w);
    cmp(cur_req, "model range", int'(range_err_o), int'(err_of(ec, ea)));
    cmp(cur_req, "model enable", int'(mod_en_o), int'(ee));
  endtask

  task automatic steps(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic ser_write(int n, logic [39:0] bits);
    for (int i = n - 1; i >= 0; i--) begin
      sdat = bits[i];
      steps(2);
      sclk = 1'b1;
      steps(3);
      sclk = 1'b0;
      steps(2);
    end
    sdat = 1'b0;
    steps(4);
  endtask

  task automatic load_pulse();
    sload = 1'b1;
    steps(3);
    sload = 1'b0;
    steps(5);
  endtask

  task automatic check_now(string req, int ecode, bit ealarm, int eword, bit eerr, bit een);
    cmp(req, "code_o", int'(code_o), ecode);
    cmp(req, "alarm_mode_o", int'(alarm_mode_o), int'(ealarm));
    cmp(req, "cur_word_o", int'(cur_word_o), eword);
    cmp(req, "range_err_o", int'(range_err_o), int'(eerr));
    cmp(req, "mod_en_o", int'(mod_en_o), int'(een));
  endtask

  task automatic alarm_write(string req, int val, bit eerr);
    cur_req = req;
    ser_write(17, 40'(val));
    load_pulse();
    check_now(req, val, 1'b1, val, eerr, 1'b1);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      finished = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d cycles expected<=150000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    q_code.push_back(0);  q_code.push_back(0);
    q_alarm.push_back(0); q_alarm.push_back(0);
    q_en.push_back(1);    q_en.push_back(1);
    repeat (4) @(negedge clk);
    check_now("R1", 0, 1'b0, 16384, 1'b0, 1'b1);   // R1 during reset
    rst_n = 1'b1;
    steps(3);
    check_now("R1", 0, 1'b0, 16384, 1'b0, 1'b1);   // R1 after reset

    // R2 / R4: 16-clock write, code unchanged until the strobe
    cur_req = "R2";
    ser_write(16, 40'hABCD);
    check_now("R2", 0, 1'b0, 16384, 1'b0, 1'b1);
    load_pulse();
    cur_req = "R4";
    check_now("R4", 43981, 1'b0, 60365, 1'b0, 1'b1); // R6 word = code + 16384

    // R5: 17-clock write selects alarm
    alarm_write("R5", 74565, 1'b0);
    // R3: strobe with no clocks restarts count, normal mode from stale bits
    cur_req = "R3";
    load_pulse();
    check_now("R3", 16'h2345, 1'b0, 16'h2345 + 16384, 1'b0, 1'b1);

    // R5 / R7: 24-clock write keeps last 17 bits (0x18001 = 98305)
    cur_req = "R5";
    ser_write(24, 40'hFF8001);
    load_pulse();
    check_now("R5", 98305, 1'b1, 98305, 1'b1, 1'b1);

    // R7 boundaries
    alarm_write("R7", 98304, 1'b0);
    alarm_write("R7", 14336, 1'b0);
    alarm_write("R7", 14335, 1'b1);

    // R3: 33 clocks wrap to count 1 -> normal, low 16 bits kept
    cur_req = "R3";
    ser_write(33, 40'h1_0000_1234);
    load_pulse();
    check_now("R3", 16'h1234, 1'b0, 16'h1234 + 16384, 1'b0, 1'b1);
    // R3: 32 clocks wrap to count 0 -> normal
    ser_write(32, 40'hDEAD_BEEF);
    load_pulse();
    check_now("R3", 16'hBEEF, 1'b0, 16'hBEEF + 16384, 1'b0, 1'b1);

    // R8: overload clears, ignores a write and strobe, releases to zero code
    alarm_write("R8", 50000, 1'b0);
    cur_req = "R8";
    ovl = 1'b1;
    steps(6);
    check_now("R8", 0, 1'b0, 16384, 1'b0, 1'b0);
    ser_write(17, 40'h1FFFF);
    load_pulse();
    check_now("R8", 0, 1'b0, 16384, 1'b0, 1'b0);
    ovl = 1'b0;
    steps(6);
    check_now("R8", 0, 1'b0, 16384, 1'b0, 1'b1);
    ser_write(16, 40'h0042);
    load_pulse();
    check_now("R8", 66, 1'b0, 16450, 1'b0, 1'b1);

    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule